// File: doc/BRIEF.md
# UART Receive Queue with Threshold and Idle Timeout

This block buffers received characters between a UART deserializer and the CPU side of a serial port. Each accepted character is stored together with its error flags (parity, framing, break), and the oldest entry is always presented at the read outputs. A read strobe removes that entry.

Data readiness is reported in two ways. A threshold flag rises once the fill level reaches one of four programmable levels. An idle timeout flag rises when characters sit below that threshold for four character times plus a fixed margin, measured in bit-time ticks. This means the CPU also collects short bursts that never reach the threshold. The timeout length follows the programmed word length. A FIFO clear input empties the queue and drops both flags.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset, the queue is empty: `count_o` = 0, `empty_o` = 1, and `full_o`, `trig_o`, `timeout_o` and `overrun_o` are all 0.
- R2: Entries are read out in the order they were written. Each entry comes out with the error flags written with it. The oldest entry is visible on `rd_data_o`/`rd_err_o` before the read strobe that removes it.
- R3: The queue holds 16 entries, and `full_o` is 1 at 16. A write while full, with no read in the same cycle, discards the byte, leaves the count and contents unchanged, and sets `overrun_o`. `overrun_o` stays set until a FIFO clear.
- R4: A read strobe while empty is ignored: the count stays 0 and nothing else changes.
- R5: `trig_o` is 1 exactly when `count_o` is at least the selected level. The `trig_sel_i` codes are 0 → 1, 1 → 4, 2 → 8 and 3 → 14 entries.
- R6: The word length is 5 + `word_len_i` bits. `timeout_o` rises after 4 × word length + 12 bit ticks (32, 36, 40 or 44). Cycles without `bit_tick_i` do not count.
- R7: Every accepted write and every accepted read restarts the timeout count. The count advances only while the queue is non-empty and below the selected level.
- R8: `timeout_o` clears on the next accepted read. A write does not clear it.
- R9: `fifo_clr_i` empties the queue and clears `timeout_o` and `overrun_o`. It takes priority over a write or read in the same cycle.
- R10: A read and a write in the same cycle while full both take effect: the count stays 16 and the new byte becomes the newest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe from deserializer |
| wr_data_i | input | 8 | Received byte |
| wr_err_i | input | 3 | Error flags of the byte |
| rd_i | input | 1 | Read strobe, removes oldest entry |
| fifo_clr_i | input | 1 | Empties queue, clears flags |
| trig_sel_i | input | 2 | Threshold select code |
| word_len_i | input | 2 | Word length code (5 + value bits) |
| bit_tick_i | input | 1 | One pulse per bit time |
| rd_data_o | output | 8 | Oldest byte |
| rd_err_o | output | 3 | Error flags of oldest byte |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| count_o | output | 5 | Number of stored entries |
| overrun_o | output | 1 | Byte dropped on full, sticky |
| trig_o | output | 1 | Fill level at or above threshold |
| timeout_o | output | 1 | Idle timeout reached |

## Verification
The hardest case to reach is the timeout at its exact boundary while a restart lands partway through the count. The flag can only be seen after dozens of bit ticks, and any write, read or crossing of the threshold silently resets the count. The stimulus places one entry below the threshold and applies exactly one tick fewer than the limit, with idle cycles between ticks. It then applies the final tick, and repeats this for all four word lengths. A second run writes partway through the count and proves that the full length is needed again. Order, flags and overrun are covered by filling the queue completely and sweeping every threshold code at every fill level.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  parameter int DW = 8;
  parameter int EW = 3;

  typedef struct packed {
    logic [EW-1:0] err;
    logic [DW-1:0] data;
  } rx_entry_t;

  // threshold per select code, scaled to depth (16 -> 1,4,8,14)
  function automatic int trig_level(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            wr_i,
  input  rx_entry_t       wdata_i,
  input  logic            rd_i,
  output rx_entry_t       rdata_o,
  output logic [CW-1:0]   count_o,
  output logic            full_o,
  output logic            empty_o,
  output logic            wr_ok_o,
  output logic            rd_ok_o,
  output logic            ovr_o
);
  localparam bit POW2 = (DEPTH == (1 << AW));

  rx_entry_t         mem_q [DEPTH];
  logic [AW-1:0]     wp_q, rp_q, wp_n, rp_n;
  logic [CW-1:0]     cnt_q;
  logic              ovr_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rd_ok_o = rd_i && !empty_o && !clr_i;
  assign wr_ok_o = wr_i && (!full_o || rd_ok_o) && !clr_i;

  generate
    if (POW2) begin : g_wrap_nat
      assign wp_n = wp_q + 1'b1;
      assign rp_n = rp_q + 1'b1;
    end else begin : g_wrap_cmp
      assign wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      assign rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (wr_ok_o) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (wr_ok_o) wp_q <= wp_n;
      if (rd_ok_o) rp_q <= rp_n;
      case ({wr_ok_o, rd_ok_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (wr_i && !wr_ok_o) ovr_q <= 1'b1;
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;
  assign ovr_o   = ovr_q;

  a_r3_drop_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i && !clr_i) |=> (ovr_o && full_o));
  a_r4_empty_read_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o && !wr_i && !clr_i) |=> empty_o);
  a_r9_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (empty_o && !ovr_o));
  a_r10_full_rw_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && full_o && !clr_i) |=> full_o);
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
endmodule

// File: rtl/rxf_trig.sv
module rxf_trig
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    sel_i,
  output logic          hit_o
);
  logic [CW-1:0] lvl;
  always_comb begin
    lvl   = CW'(trig_level(sel_i, DEPTH));
    hit_o = (count_i >= lvl);
  end
endmodule

// File: rtl/rxf_tmo.sv
module rxf_tmo #(
  parameter int WL_W     = 2,
  parameter int BASE_LEN = 5,
  parameter int CHARS    = 4,
  parameter int MARGIN   = 12,
  localparam int MAX_LIM = CHARS * (BASE_LEN + (1 << WL_W) - 1) + MARGIN,
  localparam int TW      = $clog2(MAX_LIM + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            restart_i,
  input  logic            rd_ok_i,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic [WL_W-1:0] word_len_i,
  output logic            tmo_o
);
  logic [TW-1:0] cnt_q, lim;
  logic          tmo_q;

  assign lim = TW'(CHARS * (BASE_LEN + int'(word_len_i)) + MARGIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      if (rd_ok_i) tmo_q <= 1'b0;
      if (restart_i || !run_i) begin
        cnt_q <= '0;
      end else if (tick_i && !tmo_q) begin
        if (cnt_q == lim - 1'b1) begin
          cnt_q <= '0;
          tmo_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign tmo_o = tmo_q;

  a_r6_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_o) |-> $past(tick_i));
  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok_i |=> !tmo_o);
  a_r9_clear_drops_tmo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tmo_o);
  a_r7_no_rise_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !tmo_o) |=> !tmo_o);
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WL_W  = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [EW-1:0]   wr_err_i,
  input  logic            rd_i,
  input  logic            fifo_clr_i,
  input  logic [1:0]      trig_sel_i,
  input  logic [WL_W-1:0] word_len_i,
  input  logic            bit_tick_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [EW-1:0]   rd_err_o,
  output logic            empty_o,
  output logic            full_o,
  output logic [CW-1:0]   count_o,
  output logic            overrun_o,
  output logic            trig_o,
  output logic            timeout_o
);
  rx_entry_t wdata, rdata;
  logic      wr_ok, rd_ok;

  assign wdata.data = wr_data_i;
  assign wdata.err  = wr_err_i;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .clr_i(fifo_clr_i), .wr_i, .wdata_i(wdata), .rd_i,
    .rdata_o(rdata), .count_o, .full_o, .empty_o,
    .wr_ok_o(wr_ok), .rd_ok_o(rd_ok), .ovr_o(overrun_o)
  );

  rxf_trig #(.DEPTH(DEPTH)) u_trig (
    .count_i(count_o), .sel_i(trig_sel_i), .hit_o(trig_o)
  );

  rxf_tmo #(.WL_W(WL_W)) u_tmo (
    .clk_i, .rst_ni, .clr_i(fifo_clr_i), .restart_i(wr_ok || rd_ok),
    .rd_ok_i(rd_ok), .run_i(!empty_o && !trig_o), .tick_i(bit_tick_i),
    .word_len_i, .tmo_o(timeout_o)
  );

  assign rd_data_o = rdata.data;
  assign rd_err_o  = rdata.err;

  a_r5_full_above_any_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> trig_o);
  a_r7_tmo_only_below_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(!trig_o && !empty_o));
endmodule

// File: tb/sim_rx_fifo_trig.sv
module sim_rx_fifo_trig;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, rd = 0, clr = 0, tick = 0;
  logic [7:0] wd = 0;
  logic [2:0] we = 0;
  logic [1:0] sel = 0, wl = 0;
  logic [7:0] rdd;
  logic [2:0] rde;
  logic emp, ful, ovr, trg, tmo;
  logic [4:0] cnt;
  int errs = 0, checks = 0;
  logic [10:0] mq[$];

  always #2 clk = ~clk;

  rx_fifo_trig u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wd), .wr_err_i(we),
    .rd_i(rd), .fifo_clr_i(clr), .trig_sel_i(sel), .word_len_i(wl),
    .bit_tick_i(tick), .rd_data_o(rdd), .rd_err_o(rde), .empty_o(emp),
    .full_o(ful), .count_o(cnt), .overrun_o(ovr), .trig_o(trg), .timeout_o(tmo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl(input int s);
    return s == 0 ? 1 : s == 1 ? 4 : s == 2 ? 8 : 14;
  endfunction

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    wr = 1; wd = d; we = e;
    @(negedge clk);
    wr = 0;
    if (mq.size() < 16) mq.push_back({e, d});
  endtask

  task automatic pop_chk(input string req);
    logic [10:0] x;
    x = mq.pop_front();
    chk(rdd == x[7:0], req, rdd, x[7:0]);
    chk(rde == x[10:8], req, rde, x[10:8]);
    rd = 1;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic tickc();
    tick = 1;
    @(negedge clk);
    tick = 0;
    @(negedge clk);
  endtask

  task automatic do_clr();
    clr = 1;
    @(negedge clk);
    clr = 0;
    mq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int lim;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cnt == 0 && emp && !ful, "R1", cnt, 0);
    chk(!trg && !tmo && !ovr, "R1", {trg, tmo, ovr}, 0);

    // R2/R5: fill with threshold sweep at every level
    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 4; s++) begin
        sel = 2'(s); #1;
        chk(trg == (i >= lvl(s)), "R5", trg, i >= lvl(s));
      end
      push(8'(i * 17 + 3), 3'(i % 8));
      chk(cnt == 5'(i + 1), "R2", cnt, i + 1);
    end
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); #1;
      chk(trg == 1'b1, "R5", trg, 1);
    end
    chk(ful == 1'b1, "R3", ful, 1);
    // R3 write to full dropped
    push(8'hee, 3'd7);
    chk(ovr == 1'b1 && cnt == 16, "R3", {ovr, cnt}, {1'b1, 5'd16});
    for (int i = 0; i < 16; i++) pop_chk("R2");
    chk(emp && cnt == 0, "R2", cnt, 0);
    chk(ovr == 1'b1, "R3 sticky", ovr, 1);
    // R4 read on empty
    rd = 1; @(negedge clk); rd = 0;
    chk(cnt == 0 && emp, "R4", cnt, 0);

    // R6 timeout length for all word lengths
    sel = 2'd2;
    for (int w = 0; w < 4; w++) begin
      do_clr();
      wl = 2'(w);
      lim = 4 * (w + 5) + 12;
      push(8'h5a, 3'd0);
      repeat (lim - 1) tickc();
      chk(tmo == 1'b0, "R6 early", tmo, 0);
      tickc();
      chk(tmo == 1'b1, "R6 edge", tmo, 1);
    end

    // R7 restart on write; R8 write keeps flag, read clears
    do_clr();
    wl = 2'd2; lim = 40;
    push(8'h11, 3'd1);
    repeat (lim - 1) tickc();
    push(8'h22, 3'd2);
    repeat (lim - 1) tickc();
    chk(tmo == 1'b0, "R7 restart", tmo, 0);
    tickc();
    chk(tmo == 1'b1, "R7", tmo, 1);
    push(8'h33, 3'd3);
    chk(tmo == 1'b1, "R8 write keeps", tmo, 1);
    pop_chk("R8");
    chk(tmo == 1'b0, "R8 read clears", tmo, 0);
    // R7 restart on read
    repeat (lim - 1) tickc();
    pop_chk("R7");
    repeat (lim - 1) tickc();
    chk(tmo == 1'b0, "R7 read restart", tmo, 0);
    tickc();
    chk(tmo == 1'b1, "R7", tmo, 1);

    // R7 no counting at/above level or when empty
    do_clr();
    sel = 2'd0;
    push(8'h44, 3'd0);
    repeat (60) tickc();
    chk(tmo == 1'b0, "R7 at level", tmo, 0);
    do_clr();
    repeat (60) tickc();
    chk(tmo == 1'b0, "R7 empty", tmo, 0);

    // R9 clear beats write, clears flags
    sel = 2'd2;
    for (int i = 0; i < 17; i++) push(8'(i), 3'd0);
    chk(ovr == 1'b1, "R3", ovr, 1);
    clr = 1; wr = 1; wd = 8'h99;
    @(negedge clk);
    clr = 0; wr = 0; mq.delete();
    chk(cnt == 0 && emp && !ovr && !tmo, "R9", cnt, 0);

    // R10 simultaneous read/write when full
    for (int i = 0; i < 16; i++) push(8'(8'h80 + i), 3'(i % 8));
    chk(ful == 1'b1, "R10", ful, 1);
    chk(rdd == 8'h80, "R10", rdd, 8'h80);
    wr = 1; rd = 1; wd = 8'hc5; we = 3'd5;
    @(negedge clk);
    wr = 0; rd = 0;
    void'(mq.pop_front());
    mq.push_back({3'd5, 8'hc5});
    chk(cnt == 16 && !ovr, "R10", cnt, 16);
    for (int i = 0; i < 16; i++) pop_chk("R10");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule